// File: doc/BRIEF.md
# Bit-Mapped Infrared-Link Interrupt Gatherer

This block gathers the eight interrupt causes of an infrared serial link into one identification byte and one interrupt line. Each cause owns one bit of that byte. Two causes are live levels that come from the receive and transmit data paths. The other six are sticky flags that are set by one-cycle event pulses. Each sticky flag is cleared by the side effect of a particular register access. The surrounding bus logic passes those accesses in as one-cycle strobes.

Each cause has its own enable bit, held in an 8-bit enable register. A flag latches even while its enable bit is clear. It shows in the identification byte only when it is enabled. The interrupt line is the registered OR of the enabled pending causes, with no ranking between them. The FIFOs, the CRC check and the frame logic are outside this block and appear only as inputs.

Top module: `irq_ident_ctrl`

## Requirements
- R1: After reset all sticky flags and all enable bits are zero, so `ident` reads 0x00 and `irq` is low, whatever the level inputs do.
- R2: `ident[i]` is the pending state of cause i ANDed with enable bit i. A sticky flag still latches while its enable bit is zero, and it appears in `ident` in the cycle after that enable bit is written to one.
- R3: `irq` is registered: in each cycle it equals the OR of all eight `ident` bits of the previous cycle, with no priority between causes.
- R4: `ident[0]` follows `rx_ready` when `fifo_en` is 0 and follows `rx_above_trig` when `fifo_en` is 1, combinationally and without latching.
- R5: `ident[1]` follows `tx_hold_empty` when `fifo_en` is 0 and follows `tx_below_trig` when `fifo_en` is 1, combinationally and without latching.
- R6: Bit 2 is set by `ev_rx_last` and cleared by `rd_rhr`.
- R7: Bit 3 is set by `ev_rx_overrun` and cleared only by `rd_resume`. A read of the identification byte leaves it set.
- R8: Bit 4 is set by `ev_stat_trig` and cleared by any `rd_stat`.
- R9: Bit 5 is set by `ev_tx_done` and cleared by either `rd_resume` or `rd_iir`.
- R10: Bit 6 is set by `ev_stat_err`. It is cleared only by a `rd_stat` while `stat_level` equals 1, which is the read that empties the status FIFO. Reads made at a higher level leave it set.
- R11: Bit 7 is set by `ev_rx_eof` and cleared by `rd_iir`. A read of the resume register leaves it set.
- R12: When a set pulse and a clearing strobe hit the same flag in one cycle, the flag stays set. An access that clears a flag sees the pre-clear value on `ident` in its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_wr | input | 1 | Write strobe for the enable register |
| en_wdata | input | 8 | New enable bits, one per cause |
| fifo_en | input | 1 | 1 selects FIFO-mode level conditions for bits 0 and 1 |
| rx_ready | input | 1 | Receive holding register holds data (non-FIFO mode) |
| rx_above_trig | input | 1 | Receive FIFO above its trigger level (FIFO mode) |
| tx_hold_empty | input | 1 | Transmit holding register empty (non-FIFO mode) |
| tx_below_trig | input | 1 | Transmit FIFO below its trigger level (FIFO mode) |
| ev_rx_last | input | 1 | Pulse: last byte of a frame reached the receive read port |
| ev_rx_overrun | input | 1 | Pulse: receiver pushed into a full receive FIFO |
| ev_stat_trig | input | 1 | Pulse: status FIFO reached its trigger level |
| ev_tx_done | input | 1 | Pulse: final bit of a transmitted frame sent, with or without underrun |
| ev_stat_err | input | 1 | Pulse: CRC, abort or length error entry written to the status FIFO |
| ev_rx_eof | input | 1 | Pulse: end of frame received |
| rd_rhr | input | 1 | Strobe: receive holding register read |
| rd_resume | input | 1 | Strobe: resume register read |
| rd_stat | input | 1 | Strobe: status FIFO read |
| rd_iir | input | 1 | Strobe: identification register read |
| stat_level | input | 4 | Status FIFO entry count before the current read |
| ident | output | 8 | Identification byte: enabled pending causes |
| irq | output | 1 | Registered interrupt request |

## Verification
The collision that matters is a set pulse meeting the access that clears the same flag in one cycle. The bench provokes it by driving the end-of-frame pulse together with the identification read, and the overrun pulse together with the resume read, both in a single stimulus cycle. It judges the result on `ident` one cycle later, where each bit must still be set. A separate directed test holds a clearing strobe and samples `ident` within that same cycle, to show that the read sees the value from before the clear.

// File: rtl/irq_ident_pkg.sv
// Package: irq_ident_pkg
// Shared constants for the interrupt gatherer: how many causes there are,
// where each one sits in the identification byte, and how the sticky causes
// are numbered inside the sticky bank.
// Assumes: the byte layout is fixed; the sticky causes occupy the upper six bits.
package irq_ident_pkg;
    localparam int unsigned NUM_SRC     = 8;
    localparam int unsigned NUM_LEVEL   = 2;
    localparam int unsigned NUM_STICKY  = NUM_SRC - NUM_LEVEL;
    localparam int unsigned STICKY_BASE = NUM_LEVEL;

    // Bit positions in the identification byte
    localparam int unsigned BIT_RX_DATA  = 0;
    localparam int unsigned BIT_TX_SPACE = 1;
    localparam int unsigned BIT_RX_LAST  = 2;
    localparam int unsigned BIT_OVERRUN  = 3;
    localparam int unsigned BIT_STAT_TRG = 4;
    localparam int unsigned BIT_TX_DONE  = 5;
    localparam int unsigned BIT_STAT_ERR = 6;
    localparam int unsigned BIT_RX_EOF   = 7;

    // Index of each sticky cause inside the sticky bank
    localparam int unsigned STK_RX_LAST  = BIT_RX_LAST  - STICKY_BASE;
    localparam int unsigned STK_OVERRUN  = BIT_OVERRUN  - STICKY_BASE;
    localparam int unsigned STK_STAT_TRG = BIT_STAT_TRG - STICKY_BASE;
    localparam int unsigned STK_TX_DONE  = BIT_TX_DONE  - STICKY_BASE;
    localparam int unsigned STK_STAT_ERR = BIT_STAT_ERR - STICKY_BASE;
    localparam int unsigned STK_RX_EOF   = BIT_RX_EOF   - STICKY_BASE;

    // Strobes bundled for the clear decoder
    typedef struct packed {
        logic rhr;
        logic resume;
        logic stat;
        logic iir;
    } rd_strobe_t;
endpackage

// File: rtl/irq_lvl_select.sv
// Module: irq_lvl_select
// Picks, for each level-type cause, either the non-FIFO condition or the
// FIFO-mode condition, depending on the mode input. The result is purely
// combinational; nothing is stored.
// Assumes: both condition vectors are already synchronous to clk.
module irq_lvl_select #(
    parameter int unsigned N = 2
) (
    input  logic         fifo_mode,
    input  logic [N-1:0] plain_cond,
    input  logic [N-1:0] fifo_cond,
    output logic [N-1:0] sel_cond
);
    for (genvar g = 0; g < N; g++) begin : g_sel
        // Per-cause mode multiplexer
        always_comb begin
            sel_cond[g] = fifo_mode ? fifo_cond[g] : plain_cond[g];
        end
    end
endmodule

// File: rtl/irq_clr_decode.sv
// Module: irq_clr_decode
// Turns the register-access strobes into one clear request per sticky
// cause. The status-error flag is cleared only by the read that drains the
// status FIFO, that is, a read made while exactly one entry remains.
// Assumes: stat_level is the count before the current read.
module irq_clr_decode
    import irq_ident_pkg::*;
#(
    parameter int unsigned LVL_W = 4
) (
    input  rd_strobe_t             rd,
    input  logic [LVL_W-1:0]       stat_level,
    output logic [NUM_STICKY-1:0]  clr
);
    logic stat_drain;

    // Detect the read that empties the status FIFO
    always_comb begin
        stat_drain = rd.stat && (stat_level == LVL_W'(1));
    end

    // Map each access to the flags it clears
    always_comb begin
        clr               = '0;
        clr[STK_RX_LAST]  = rd.rhr;
        clr[STK_OVERRUN]  = rd.resume;
        clr[STK_STAT_TRG] = rd.stat;
        clr[STK_TX_DONE]  = rd.resume | rd.iir;
        clr[STK_STAT_ERR] = stat_drain;
        clr[STK_RX_EOF]   = rd.iir;
    end
endmodule

// File: rtl/irq_sticky_bank.sv
// Module: irq_sticky_bank
// A row of set-dominant sticky flags. A set pulse always wins over a clear
// request in the same cycle.
// Assumes: set and clr are single-cycle, synchronous to clk.
module irq_sticky_bank #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag_q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // Hold, set or clear one flag; set has priority
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[g] <= 1'b0;
            end else if (set[g]) begin
                flag_q[g] <= 1'b1;
            end else if (clr[g]) begin
                flag_q[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/irq_out_stage.sv
// Module: irq_out_stage
// Masks the pending causes with their enables to form the identification
// byte, and registers the OR of that byte as the interrupt request.
// Assumes: no ranking among causes; any enabled pending cause raises irq.
module irq_out_stage #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] enable,
    output logic [N-1:0] ident,
    output logic         irq
);
    // Mask pending causes with their enables
    always_comb begin
        ident = pend & enable;
    end

    // Register the OR of all enabled pending causes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= |ident;
        end
    end
endmodule

// File: rtl/irq_ident_ctrl.sv
// Module: irq_ident_ctrl (top)
// Gathers eight infrared-link interrupt causes into a bit-mapped
// identification byte and one registered interrupt line. Bits 0 and 1 are
// live levels picked by the FIFO mode. Bits 2 to 7 are sticky flags, each
// cleared by the side effect of its own register access.
// Assumes: strobes and event pulses last one cycle; stat_level counts the
// status FIFO entries before the current read.
module irq_ident_ctrl
    import irq_ident_pkg::*;
#(
    parameter int unsigned STAT_DEPTH = 8,
    localparam int unsigned LVL_W     = $clog2(STAT_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_wr,
    input  logic [7:0]         en_wdata,
    input  logic               fifo_en,
    input  logic               rx_ready,
    input  logic               rx_above_trig,
    input  logic               tx_hold_empty,
    input  logic               tx_below_trig,
    input  logic               ev_rx_last,
    input  logic               ev_rx_overrun,
    input  logic               ev_stat_trig,
    input  logic               ev_tx_done,
    input  logic               ev_stat_err,
    input  logic               ev_rx_eof,
    input  logic               rd_rhr,
    input  logic               rd_resume,
    input  logic               rd_stat,
    input  logic               rd_iir,
    input  logic [LVL_W-1:0]   stat_level,
    output logic [7:0]         ident,
    output logic               irq
);
    logic [NUM_SRC-1:0]    en_q;
    logic [NUM_LEVEL-1:0]  lvl_cond;
    logic [NUM_STICKY-1:0] sticky_set;
    logic [NUM_STICKY-1:0] sticky_clr;
    logic [NUM_STICKY-1:0] sticky_q;
    logic [NUM_SRC-1:0]    pend;
    rd_strobe_t            rd_bus;

    // Enable register, loaded by its write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

    // Gather event pulses and access strobes into vectors
    always_comb begin
        sticky_set               = '0;
        sticky_set[STK_RX_LAST]  = ev_rx_last;
        sticky_set[STK_OVERRUN]  = ev_rx_overrun;
        sticky_set[STK_STAT_TRG] = ev_stat_trig;
        sticky_set[STK_TX_DONE]  = ev_tx_done;
        sticky_set[STK_STAT_ERR] = ev_stat_err;
        sticky_set[STK_RX_EOF]   = ev_rx_eof;
        rd_bus.rhr               = rd_rhr;
        rd_bus.resume            = rd_resume;
        rd_bus.stat              = rd_stat;
        rd_bus.iir               = rd_iir;
    end

    irq_lvl_select #(.N(NUM_LEVEL)) u_lvl (
        .fifo_mode  (fifo_en),
        .plain_cond ({tx_hold_empty, rx_ready}),
        .fifo_cond  ({tx_below_trig, rx_above_trig}),
        .sel_cond   (lvl_cond)
    );

    irq_clr_decode #(.LVL_W(LVL_W)) u_clr (
        .rd         (rd_bus),
        .stat_level (stat_level),
        .clr        (sticky_clr)
    );

    irq_sticky_bank #(.N(NUM_STICKY)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .set    (sticky_set),
        .clr    (sticky_clr),
        .flag_q (sticky_q)
    );

    // Assemble all pending causes into identification-byte order
    always_comb begin
        pend = {sticky_q, lvl_cond};
    end

    irq_out_stage #(.N(NUM_SRC)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .pend   (pend),
        .enable (en_q),
        .ident  (ident),
        .irq    (irq)
    );
endmodule

// File: rtl/irq_ident_chk.sv
// Module: irq_ident_chk
// Property checker bound into irq_ident_ctrl. It watches the enable
// register, the sticky flags and the ports.
// Assumes: the sticky bank is numbered as in irq_ident_pkg.
module irq_ident_chk
    import irq_ident_pkg::*;
#(
    parameter int unsigned LVL_W = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_SRC-1:0]    en_q,
    input logic [NUM_STICKY-1:0] flag_q,
    input logic [7:0]            ident,
    input logic                  irq,
    input logic                  fifo_en,
    input logic                  rx_ready,
    input logic                  ev_rx_eof,
    input logic                  rd_iir,
    input logic                  ev_rx_overrun,
    input logic                  rd_resume,
    input logic                  ev_stat_err,
    input logic                  rd_stat,
    input logic [LVL_W-1:0]      stat_level
);
    // R3: irq is the registered OR of the previous identification byte
    assert_irq_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq == $past(|ident));

    // R2: no disabled cause ever shows in the identification byte
    assert_ident_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ident & ~en_q) == 8'h00);

    // R4: in non-FIFO mode bit 0 tracks data-ready through its enable
    assert_rx_plain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> (ident[BIT_RX_DATA] == (rx_ready & en_q[BIT_RX_DATA])));

    // R11: an end-of-frame pulse always leaves its flag set
    assert_eof_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_eof |=> flag_q[STK_RX_EOF]);

    // R11: the end-of-frame flag survives any cycle without an ident read
    assert_eof_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[STK_RX_EOF] && !rd_iir) |=> flag_q[STK_RX_EOF]);

    // R7: a resume read with no new overrun clears the overrun flag
    assert_overrun_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_resume && !ev_rx_overrun) |=> !flag_q[STK_OVERRUN]);

    // R10: the error flag holds until the draining status read
    assert_err_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[STK_STAT_ERR] && !(rd_stat && stat_level == LVL_W'(1)))
        |=> flag_q[STK_STAT_ERR]);

    // R12: a set pulse beats a same-cycle status drain
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stat_err |=> flag_q[STK_STAT_ERR]);
endmodule

bind irq_ident_ctrl irq_ident_chk #(.LVL_W(LVL_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_q          (en_q),
    .flag_q        (sticky_q),
    .ident         (ident),
    .irq           (irq),
    .fifo_en       (fifo_en),
    .rx_ready      (rx_ready),
    .ev_rx_eof     (ev_rx_eof),
    .rd_iir        (rd_iir),
    .ev_rx_overrun (ev_rx_overrun),
    .rd_resume     (rd_resume),
    .ev_stat_err   (ev_stat_err),
    .rd_stat       (rd_stat),
    .stat_level    (stat_level)
);

// File: tb/test_irq_ident_ctrl.sv
`timescale 1ns/1ps
// Bench for irq_ident_ctrl: a vector table of sticky-flag stimulus, then
// directed tests for reset, masking, level modes and read-before-clear.
module test_irq_ident_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       en_wr;
    logic [7:0] en_wdata;
    logic       fifo_en, rx_ready, rx_above_trig, tx_hold_empty, tx_below_trig;
    logic       ev_rx_last, ev_rx_overrun, ev_stat_trig, ev_tx_done, ev_stat_err, ev_rx_eof;
    logic       rd_rhr, rd_resume, rd_stat, rd_iir;
    logic [3:0] stat_level;
    logic [7:0] ident;
    logic       irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_ident_ctrl i_irq_ident_ctrl (
        .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
        .fifo_en(fifo_en), .rx_ready(rx_ready), .rx_above_trig(rx_above_trig),
        .tx_hold_empty(tx_hold_empty), .tx_below_trig(tx_below_trig),
        .ev_rx_last(ev_rx_last), .ev_rx_overrun(ev_rx_overrun),
        .ev_stat_trig(ev_stat_trig), .ev_tx_done(ev_tx_done),
        .ev_stat_err(ev_stat_err), .ev_rx_eof(ev_rx_eof),
        .rd_rhr(rd_rhr), .rd_resume(rd_resume), .rd_stat(rd_stat), .rd_iir(rd_iir),
        .stat_level(stat_level), .ident(ident), .irq(irq)
    );

    // ev bits: 0 last-byte, 1 overrun, 2 stat-trig, 3 tx-done, 4 stat-err, 5 eof
    // rd bits: 0 rhr, 1 resume, 2 stat, 3 iir
    typedef struct packed {
        logic [5:0] ev;
        logic [3:0] rd;
        logic [3:0] lvl;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [0:NV-1] = '{
        '{6'b000001, 4'b0000, 4'd0, 8'h04},  // R6 set
        '{6'b000000, 4'b0001, 4'd0, 8'h00},  // R6 clear by rhr read
        '{6'b000010, 4'b0000, 4'd0, 8'h08},  // R7 set
        '{6'b000000, 4'b1000, 4'd0, 8'h08},  // R7 ident read ignored
        '{6'b000000, 4'b0010, 4'd0, 8'h00},  // R7 resume clears
        '{6'b000100, 4'b0000, 4'd0, 8'h10},  // R8 set
        '{6'b000000, 4'b0100, 4'd3, 8'h00},  // R8 any stat read clears
        '{6'b001000, 4'b0000, 4'd0, 8'h20},  // R9 set
        '{6'b000000, 4'b1000, 4'd0, 8'h00},  // R9 ident read clears
        '{6'b001000, 4'b0000, 4'd0, 8'h20},  // R9 set again
        '{6'b000000, 4'b0010, 4'd0, 8'h00},  // R9 resume clears
        '{6'b010000, 4'b0000, 4'd0, 8'h40},  // R10 set
        '{6'b000000, 4'b0100, 4'd3, 8'h40},  // R10 not yet empty
        '{6'b000000, 4'b0100, 4'd2, 8'h40},  // R10 not yet empty
        '{6'b000000, 4'b0100, 4'd1, 8'h00},  // R10 drained
        '{6'b100000, 4'b0000, 4'd0, 8'h80},  // R11 set
        '{6'b000000, 4'b0010, 4'd0, 8'h80},  // R11 resume ignored
        '{6'b000000, 4'b1000, 4'd0, 8'h00},  // R11 ident read clears
        '{6'b100000, 4'b1000, 4'd0, 8'h80},  // R12 set beats ident read
        '{6'b000010, 4'b0010, 4'd0, 8'h88},  // R12 set beats resume read
        '{6'b000000, 4'b1010, 4'd0, 8'h00},  // R12 follow-up clears
        '{6'b111111, 4'b0000, 4'd0, 8'hFC},  // R3 all sources, no ranking
        '{6'b000000, 4'b1111, 4'd1, 8'h00}   // R3 all cleared together
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        ev_rx_last = 0; ev_rx_overrun = 0; ev_stat_trig = 0;
        ev_tx_done = 0; ev_stat_err = 0; ev_rx_eof = 0;
        rd_rhr = 0; rd_resume = 0; rd_stat = 0; rd_iir = 0;
        stat_level = 0; en_wr = 0;
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        @(negedge clk);
        {ev_rx_eof, ev_stat_err, ev_tx_done, ev_stat_trig, ev_rx_overrun, ev_rx_last} = v.ev;
        {rd_iir, rd_stat, rd_resume, rd_rhr} = v.rd;
        stat_level = v.lvl;
        @(negedge clk);
        idle();
        #1;
        check($sformatf("vector %0d ident", idx), ident, v.exp);
        @(negedge clk);
        #1;
        check($sformatf("R3 vector %0d irq", idx), {7'b0, irq}, {7'b0, (v.exp != 8'h00)});
    endtask

    task automatic write_en(input logic [7:0] val);
        @(negedge clk);
        en_wr = 1; en_wdata = val;
        @(negedge clk);
        en_wr = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle();
        en_wdata = 0;
        fifo_en = 0; rx_ready = 1; rx_above_trig = 1; tx_hold_empty = 1; tx_below_trig = 1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset ident", ident, 8'h00);
        check("R1 reset irq", {7'b0, irq}, 8'h00);
        rst_n = 1;
        @(negedge clk);
        #1;
        check("R1 after reset ident with levels high", ident, 8'h00);
        rx_ready = 0; rx_above_trig = 0; tx_hold_empty = 0; tx_below_trig = 0;

        // R2: flag latches while disabled, appears once enabled
        @(negedge clk);
        ev_rx_eof = 1;
        @(negedge clk);
        ev_rx_eof = 0;
        #1;
        check("R2 disabled flag hidden", ident, 8'h00);
        @(negedge clk);
        #1;
        check("R2 disabled irq low", {7'b0, irq}, 8'h00);
        write_en(8'h80);
        #1;
        check("R2 enabled flag shows", ident, 8'h80);
        check("R3 irq lags ident", {7'b0, irq}, 8'h00);
        @(negedge clk);
        #1;
        check("R3 irq rises next cycle", {7'b0, irq}, 8'h01);

        // R12: the clearing read sees the pre-clear value in its own cycle
        @(negedge clk);
        rd_iir = 1;
        #1;
        check("R12 read sees pre-clear value", ident, 8'h80);
        @(negedge clk);
        rd_iir = 0;
        #1;
        check("R11 cleared after ident read", ident, 8'h00);

        write_en(8'hFF);
        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R4 and R5: level sources follow the selected mode
        @(negedge clk);
        fifo_en = 0; rx_ready = 1; rx_above_trig = 0; tx_hold_empty = 0; tx_below_trig = 1;
        #1;
        check("R4 R5 plain mode", ident, 8'h01);
        fifo_en = 1;
        #1;
        check("R4 R5 fifo mode", ident, 8'h02);
        rx_above_trig = 1;
        #1;
        check("R4 fifo above trigger", ident, 8'h03);
        @(negedge clk);
        #1;
        check("R3 irq from level source", {7'b0, irq}, 8'h01);
        rx_above_trig = 0; tx_below_trig = 0;
        #1;
        check("R4 R5 levels not latched", ident, 8'h00);
        @(negedge clk);
        #1;
        check("R3 irq falls after levels drop", {7'b0, irq}, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule